// File: doc/BRIEF.md
# E1 Sa-Bit Functional Element Detector

This block sits behind an E1 receive framer that has already found frame alignment and pulled out the spare bits. For every frame the framer presents the remote-alarm bit (A), the Sa5 bit, the four Sa6 bits and the E bit, together with a valid strobe. The block compares that sample against nine fixed wildcard patterns. These patterns carry functional-element messages on an access digital section link: loopback commands and their acknowledgement, and CRC error reports in both directions.

Each pattern owns one sticky flag in a 16-bit status word. A flag is set in the cycle after a matching sample and stays set until the host reads the word. A read is signalled by a one-cycle read strobe. It returns the current word and clears every flag on the next edge. A match that arrives in the same cycle as a read is kept. The patterns overlap, so a single sample can set several flags at once.

Top module: `fe_sa_event_detect`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `status` reads 16'h0000.
- R2: Bits 15:9 of `status` always read zero.
- R3: A valid sample with Sa5=1 and Sa6=4'b0011 sets bit 8 whatever A and E are. Sa6 is written msb first, so `smp_sa6[3]` is the first Sa6 bit.
- R4: A valid sample with Sa5=1 and Sa6=4'b0010 sets bit 7. A valid sample with Sa5=1 and Sa6=4'b0001 sets bit 6. A and E are ignored for both.
- R5: A valid sample with Sa5=0, Sa6=4'b0000 and E=0 sets bit 5 for any A.
- R6: A valid sample with Sa5=1 and E=0 sets bit 4 for any Sa6 and any A.
- R7: A valid sample with Sa5=0 and Sa6=4'b0000 sets bit 3 for any A and E.
- R8: A valid sample with A=1 and Sa5=0 sets bit 2 for any Sa6 and any E.
- R9: A valid sample with A=1, Sa5=0 and Sa6=4'b1010 sets bit 1. A valid sample with A=1, Sa5=0 and Sa6=4'b1111 sets bit 0. E is ignored for both.
- R10: A set flag stays set on every later cycle until a read strobe occurs.
- R11: A cycle with `rd_stb` high and no matching sample leaves `status` at zero on the next cycle.
- R12: When a read and a valid sample fall in the same cycle, the next word holds exactly the flags that this sample matches. Older flags are cleared.
- R13: One valid sample sets every flag whose pattern it matches, in the same cycle.
- R14: When `smp_vld` is low, the field inputs set no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Per-frame sample strobe |
| smp_a | input | 1 | A bit of the sampled frame |
| smp_sa5 | input | 1 | Sa5 bit |
| smp_sa6 | input | 4 | Sa6 nibble, first received bit in [3] |
| smp_e | input | 1 | E bit |
| rd_stb | input | 1 | Host read strobe; clears the flags after this cycle |
| status | output | 16 | Sticky flags in [8:0], zero in [15:9] |

## Verification
The bench sweeps all 128 combinations of A, Sa5, Sa6 and E, with a read on each sample. This catches a pattern that compares a don't-care field or skips a required one: such a design would miss a flag or raise a spurious one on some combination. Overlapping samples such as A=1, Sa5=0, Sa6=1010 check that a design with priority-encoded patterns would lose bit 2 or bit 1. A match placed on the read cycle shows whether a design lets the clear win and drops the event. A second check on that cycle shows whether the clear leaves old flags behind. Samples held with the valid strobe low show whether the design decodes fields that are not qualified.

// File: rtl/fe_pkg.sv
package fe_pkg;

    localparam int FE_COUNT  = 9;
    localparam int STAT_W    = 16;
    localparam int FIELD_W   = 7;   // {a, sa5, sa6[3:0], e}
    localparam int RSVD_W    = STAT_W - FE_COUNT;

    typedef struct packed {
        logic       a;
        logic       sa5;
        logic [3:0] sa6;
        logic       e;
    } sa_sample_t;

    typedef struct packed {
        logic [FIELD_W-1:0] care;
        logic [FIELD_W-1:0] value;
    } fe_pattern_t;

    // Pattern for flag index idx; care bits mark the fields that are compared.
    function automatic fe_pattern_t fe_pattern(input int idx);
        fe_pattern_t p;
        case (idx)
            8:       begin p.care = 7'b0_1_1111_0; p.value = 7'b0_1_0011_0; end
            7:       begin p.care = 7'b0_1_1111_0; p.value = 7'b0_1_0010_0; end
            6:       begin p.care = 7'b0_1_1111_0; p.value = 7'b0_1_0001_0; end
            5:       begin p.care = 7'b0_1_1111_1; p.value = 7'b0_0_0000_0; end
            4:       begin p.care = 7'b0_1_0000_1; p.value = 7'b0_1_0000_0; end
            3:       begin p.care = 7'b0_1_1111_0; p.value = 7'b0_0_0000_0; end
            2:       begin p.care = 7'b1_1_0000_0; p.value = 7'b1_0_0000_0; end
            1:       begin p.care = 7'b1_1_1111_0; p.value = 7'b1_0_1010_0; end
            0:       begin p.care = 7'b1_1_1111_0; p.value = 7'b1_0_1111_0; end
            default: begin p.care = 7'b1_1_1111_1; p.value = 7'b0_0_0000_0; end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/fe_pattern_match.sv
module fe_pattern_match
    import fe_pkg::*;
(
    input  sa_sample_t          sample,
    input  logic                sample_vld,
    output logic [FE_COUNT-1:0] hit
);
    logic [FIELD_W-1:0] fields;
    assign fields = sample;

    for (genvar g = 0; g < FE_COUNT; g++) begin : g_pat
        localparam fe_pattern_t PAT = fe_pattern(g);
        assign hit[g] = sample_vld && (((fields ^ PAT.value) & PAT.care) == '0);
    end
endmodule

// File: rtl/fe_flag_bank.sv
module fe_flag_bank #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic         clr_all,
    output logic [N-1:0] flags
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk) begin
            if (rst)
                flag_q <= 1'b0;
            else if (set_vec[g])
                flag_q <= 1'b1;   // a new event outranks the read clear
            else if (clr_all)
                flag_q <= 1'b0;
        end
        assign flags[g] = flag_q;
    end
endmodule

// File: rtl/fe_sa_event_detect.sv
module fe_sa_event_detect
    import fe_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        smp_vld,
    input  logic        smp_a,
    input  logic        smp_sa5,
    input  logic [3:0]  smp_sa6,
    input  logic        smp_e,
    input  logic        rd_stb,
    output logic [15:0] status
);
    sa_sample_t          sample;
    logic [FE_COUNT-1:0] hit;
    logic [FE_COUNT-1:0] flags;

    always_comb begin
        sample.a   = smp_a;
        sample.sa5 = smp_sa5;
        sample.sa6 = smp_sa6;
        sample.e   = smp_e;
    end

    fe_pattern_match u_match (
        .sample     (sample),
        .sample_vld (smp_vld),
        .hit        (hit)
    );

    fe_flag_bank #(.N(FE_COUNT)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_vec (hit),
        .clr_all (rd_stb),
        .flags   (flags)
    );

    assign status = {{RSVD_W{1'b0}}, flags};
endmodule

// File: rtl/fe_sa_event_detect_chk.sv
module fe_sa_event_detect_chk (
    input logic        clk,
    input logic        rst,
    input logic        smp_vld,
    input logic        smp_a,
    input logic        smp_sa5,
    input logic [3:0]  smp_sa6,
    input logic        smp_e,
    input logic        rd_stb,
    input logic [15:0] status
);
    logic rst_seen;
    always_ff @(posedge clk) rst_seen <= rst;

    always @(negedge clk) begin
        if (rst_seen === 1'b1)
            p_reset_clear_r1: assert (status == 16'h0000)
                else $error("status not clear after reset");
    end

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        status[15:9] == 7'h00);

    p_loopback1_cmd_r9: assert property (@(posedge clk) disable iff (rst)
        smp_vld && smp_a && !smp_sa5 && smp_sa6 == 4'b1111 |=> status[0] && status[2]);

    p_any_a_sa5_low_r8: assert property (@(posedge clk) disable iff (rst)
        smp_vld && smp_a && !smp_sa5 |=> status[2]);

    p_sticky_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> (status & $past(status)) == $past(status));

    p_read_clears_r11: assert property (@(posedge clk) disable iff (rst)
        rd_stb && !smp_vld |=> status == 16'h0000);

    p_read_vs_match_r12: assert property (@(posedge clk) disable iff (rst)
        rd_stb && smp_vld && smp_sa5 && smp_sa6 == 4'b0011 |=> status[8]);

    p_no_set_when_idle_r14: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> (status & ~$past(status)) == 16'h0000);
endmodule

bind fe_sa_event_detect fe_sa_event_detect_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .smp_vld (smp_vld),
    .smp_a   (smp_a),
    .smp_sa5 (smp_sa5),
    .smp_sa6 (smp_sa6),
    .smp_e   (smp_e),
    .rd_stb  (rd_stb),
    .status  (status)
);

// File: tb/fe_sa_event_detect_tb_top.sv
module fe_sa_event_detect_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_vld = 1'b0;
    logic        smp_a = 1'b0;
    logic        smp_sa5 = 1'b0;
    logic [3:0]  smp_sa6 = 4'h0;
    logic        smp_e = 1'b0;
    logic        rd_stb = 1'b0;
    logic [15:0] status;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    fe_sa_event_detect dut_i (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_a(smp_a), .smp_sa5(smp_sa5),
        .smp_sa6(smp_sa6), .smp_e(smp_e), .rd_stb(rd_stb), .status(status)
    );

    // Expected flags for one sample, written straight from the requirements.
    function automatic logic [15:0] ref_hits(input logic a, input logic s5,
                                             input logic [3:0] s6, input logic e);
        logic [15:0] h = 16'h0;
        h[8] = s5 && s6 == 4'b0011;
        h[7] = s5 && s6 == 4'b0010;
        h[6] = s5 && s6 == 4'b0001;
        h[5] = !s5 && s6 == 4'b0000 && !e;
        h[4] = s5 && !e;
        h[3] = !s5 && s6 == 4'b0000;
        h[2] = a && !s5;
        h[1] = a && !s5 && s6 == 4'b1010;
        h[0] = a && !s5 && s6 == 4'b1111;
        return h;
    endfunction

    task automatic check(input string req, input logic [15:0] exp);
        n_checks++;
        if (status !== exp) begin
            n_fail++;
            $display("FAIL %s: status=%h expected=%h", req, status, exp);
        end
    endtask

    // Drive one cycle on the falling edge; leave at the next falling edge.
    task automatic cycle(input logic vld, input logic a, input logic s5,
                         input logic [3:0] s6, input logic e, input logic rd);
        smp_vld = vld; smp_a = a; smp_sa5 = s5; smp_sa6 = s6; smp_e = e; rd_stb = rd;
        @(negedge clk);
        smp_vld = 1'b0; rd_stb = 1'b0;
    endtask

    task automatic clear_all();
        cycle(1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1);
    endtask

    task automatic t_reset();
        check("R1 reset", 16'h0000);
        @(negedge clk);
        check("R1 reset hold", 16'h0000);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", 16'h0000);
    endtask

    task automatic t_single_patterns();
        clear_all();
        cycle(1'b1, 1'b1, 1'b1, 4'b0011, 1'b1, 1'b0);
        check("R3 bit8 A=1 E=1", 16'h0100);
        clear_all();
        cycle(1'b1, 1'b0, 1'b1, 4'b0010, 1'b1, 1'b0);
        check("R4 bit7", 16'h0080);
        clear_all();
        cycle(1'b1, 1'b1, 1'b1, 4'b0001, 1'b1, 1'b0);
        check("R4 bit6", 16'h0040);
        clear_all();
        cycle(1'b1, 1'b0, 1'b1, 4'b0110, 1'b0, 1'b0);
        check("R6 bit4 alone", 16'h0010);
        clear_all();
        cycle(1'b1, 1'b1, 1'b0, 4'b0000, 1'b1, 1'b0);
        check("R7 bit3 with A=1 E=1, R8 bit2", 16'h000C);
        clear_all();
        cycle(1'b1, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0);
        check("R5 bit5 with R7 bit3", 16'h0028);
    endtask

    task automatic t_overlap();
        clear_all();
        cycle(1'b1, 1'b1, 1'b0, 4'b1010, 1'b1, 1'b0);
        check("R9 bit1 with R8 bit2 R13", 16'h0006);
        clear_all();
        cycle(1'b1, 1'b1, 1'b0, 4'b1111, 1'b0, 1'b0);
        check("R9 bit0 with R8 bit2 R13", 16'h0005);
        clear_all();
        cycle(1'b1, 1'b0, 1'b1, 4'b0011, 1'b0, 1'b0);
        check("R13 bit8 with bit4", 16'h0110);
    endtask

    task automatic t_sticky_and_read();
        logic [15:0] exp;
        clear_all();
        cycle(1'b1, 1'b0, 1'b1, 4'b0001, 1'b1, 1'b0);
        cycle(1'b1, 1'b1, 1'b0, 4'b1010, 1'b1, 1'b0);
        exp = 16'h0046;
        check("R10 accumulate", exp);
        for (int i = 0; i < 5; i++) begin
            cycle(1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0);
            check("R10 hold", exp);
        end
        clear_all();
        check("R11 read clears", 16'h0000);
        check("R2 reserved zero", 16'h0000);
        cycle(1'b1, 1'b0, 1'b1, 4'b0010, 1'b1, 1'b0);
        cycle(1'b1, 1'b1, 1'b1, 4'b0011, 1'b1, 1'b1);
        check("R12 match wins over read", 16'h0100);
    endtask

    task automatic t_invalid();
        clear_all();
        cycle(1'b0, 1'b1, 1'b0, 4'b1111, 1'b0, 1'b0);
        check("R14 vld low A/Sa5 pattern", 16'h0000);
        cycle(1'b0, 1'b0, 1'b1, 4'b0011, 1'b0, 1'b0);
        check("R14 vld low Sa6 pattern", 16'h0000);
    endtask

    task automatic t_sweep();
        clear_all();
        for (int v = 0; v < 128; v++) begin
            logic [6:0] f = 7'(v);
            cycle(1'b1, f[6], f[5], f[4:1], f[0], 1'b1);
            check("R13 sweep R2", ref_hits(f[6], f[5], f[4:1], f[0]));
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_single_patterns();
        t_overlap();
        t_sticky_and_read();
        t_invalid();
        t_sweep();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule